// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a single-port synchronous SRAM. It has a registered read path and an internal 2-bit burst address counter. Address, controls and write data are all taken at the rising clock edge. A burst opens on either of two start strobes. The first strobe is for a processor and always reads. The second is for a memory controller and reads or writes according to the write controls. Each later beat of the burst is requested by holding the advance input low. The two low address bits of each beat come from the counter, in linear or interleaved order as chosen by the order-select input.

Each data word has four 9-bit lanes. A lane is written either through its own lane enable, which counts only while the byte-write gate is low, or through the all-lanes write input, which overrides the lane enables. Read data passes through an output register, so it shows one clock later than in a flow-through part. The read-valid flag is forced low by the output-enable input and by the sleep input. Sleep also freezes the access logic and keeps the array contents.

Top module: `burst_sram`

## Requirements
- R1: Lane i covers data bits [9i+8:9i], so lane 0 is bits 8..0 and lane 3 is bits 35..27. Lane i is written when `lanewr_n` is 0 and `lane_n[i]` is 0. While `lanewr_n` is 1, `lane_n` has no effect, and an access with `allwr_n` high is then a read.
- R2: An access with `allwr_n` = 0 writes all four lanes, whatever `lane_n` holds.
- R3: Either start strobe loads `addr` as the burst base and accesses it with count 0. A `pstrb_n` start is always a read, even with write controls asserted. A `cstrb_n`-only start is a write when a lane write is requested and a read otherwise. `pstrb_n` wins when both strobes are low.
- R4: With no start strobe, `step_n` = 0 in an open burst advances the 2-bit count (wrapping 3 to 0) and accesses the next address. A cycle with neither a start nor a step performs no access.
- R5: With `ilv_order` = 0, the beat address low bits are (base + count) mod 4, and the upper bits stay at the base.
- R6: With `ilv_order` = 1, the beat address low bits are base XOR count.
- R7: A read issued at rising edge k sets `rvalid` and `rdata` after rising edge k+1. `rvalid` stays high for that one cycle only.
- R8: The block is selected only when `sel0_n` = 0, `sel_hi` = 1 and `sel1_n` = 0. A start strobe while deselected performs no access and ends the open burst, so later steps do nothing.
- R9: `rvalid` is 0 whenever `out_en_n` = 1 or `sleep` = 1.
- R10: While `sleep` = 1, start strobes and steps are ignored, no write happens and the array keeps its contents.
- R11: After reset, `rvalid` = 0, `rdata` = 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel0_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel1_n | input | 1 | Second chip select, active low |
| pstrb_n | input | 1 | Processor start strobe, read only, active low |
| cstrb_n | input | 1 | Controller start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| allwr_n | input | 1 | Write all lanes, active low |
| lanewr_n | input | 1 | Byte-write gate for lane enables, active low |
| lane_n | input | 4 | Per-lane write enables, active low |
| addr | input | ADDR_W (6) | Word address |
| wdata | input | 36 | Write data |
| ilv_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Sleep: freezes accesses, masks valid |
| out_en_n | input | 1 | Output enable, active low |
| rdata | output | 36 | Registered read data |
| rvalid | output | 1 | Read data valid |

## Verification
The bench targets several bursts that cross the mod-4 boundary. A counter that carried into the upper address bits, or that confused the linear order with the interleaved one, would return the wrong words from neighbouring addresses. A processor-strobe start with the write inputs asserted, and a controller access with lanes selected but the byte-write gate off, must both read. A design that wrote there would overwrite a word that is read back later. The bench also checks a deselected start followed by a step, sleep-time strobes, and the exact output cycle. A flow-through or two-stage-too-late path, or a burst that survives deselection, shows up as valid data in the wrong cycle.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int BURST_W = 2;

    // Low address bits of a burst beat: linear wrap or interleaved (XOR) order
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] base_lo,
        input logic [BURST_W-1:0] count,
        input logic               ilv
    );
        return ilv ? (base_lo ^ count) : (base_lo + count);
    endfunction

endpackage

// File: rtl/bsram_wr_dec.sv
module bsram_wr_dec #(
    parameter int LANES = 4
) (
    input  logic             allwr_n,
    input  logic             lanewr_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_req
);

    // Global write dominates; lane enables count only under the byte-write gate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_req[g] = !allwr_n || (!lanewr_n && !lane_n[g]);
    end

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_ok,
    input  logic              sleep,
    input  logic              pstrb_n,
    input  logic              cstrb_n,
    input  logic              step_n,
    input  logic              ilv_order,
    input  logic [LANES-1:0]  lane_req,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_go,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  lane_we,
    output logic              rd_pend,
    output logic [ADDR_W-1:0] rd_addr
);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] base;
        logic [BURST_W-1:0] cnt;
        logic              rd_pend;
        logic [ADDR_W-1:0] rd_addr;
    } ctrl_st_t;

    ctrl_st_t st_q, st_d;

    logic               start;
    logic               is_rd;
    logic               wr_any;
    logic [BURST_W-1:0] nxt_cnt;

    always_comb begin
        st_d         = st_q;
        st_d.rd_pend = 1'b0;
        start        = !pstrb_n || !cstrb_n;
        wr_any       = |lane_req;
        nxt_cnt      = st_q.cnt + BURST_W'(1);
        acc_go       = 1'b0;
        is_rd        = 1'b0;
        acc_addr     = addr;

        if (!sleep) begin
            if (start) begin
                if (sel_ok) begin
                    st_d.active = 1'b1;
                    st_d.base   = addr;
                    st_d.cnt    = '0;
                    acc_go      = 1'b1;
                    is_rd       = !pstrb_n || !wr_any;
                end else begin
                    st_d.active = 1'b0;
                end
            end else if (!step_n && st_q.active) begin
                st_d.cnt = nxt_cnt;
                acc_go   = 1'b1;
                is_rd    = !wr_any;
                acc_addr = {st_q.base[ADDR_W-1:BURST_W],
                            burst_low(st_q.base[BURST_W-1:0], nxt_cnt, ilv_order)};
            end
        end

        lane_we = (acc_go && !is_rd) ? lane_req : '0;

        if (acc_go && is_rd) begin
            st_d.rd_pend = 1'b1;
            st_d.rd_addr = acc_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_pend = st_q.rd_pend;
    assign rd_addr = st_q.rd_addr;

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    rd_pend,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    vld
);

    localparam int DEPTH = 1 << ADDR_W;

    logic vld_q, vld_d;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] out_q, out_d;

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        always_comb begin
            out_d = rd_pend ? mem[rd_addr] : out_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = out_q;
    end

    always_comb begin
        vld_d = rd_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= vld_d;
        end
    end

    assign vld = vld_q;

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel0_n,
    input  logic                    sel_hi,
    input  logic                    sel1_n,
    input  logic                    pstrb_n,
    input  logic                    cstrb_n,
    input  logic                    step_n,
    input  logic                    allwr_n,
    input  logic                    lanewr_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    ilv_order,
    input  logic                    sleep,
    input  logic                    out_en_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    logic              sel_ok;
    logic [LANES-1:0]  lane_req;
    logic [LANES-1:0]  lane_we;
    logic              acc_go;
    logic [ADDR_W-1:0] acc_addr;
    logic              rd_pend;
    logic [ADDR_W-1:0] rd_addr;
    logic              arr_vld;

    assign sel_ok = !sel0_n && sel_hi && !sel1_n;

    bsram_wr_dec #(.LANES(LANES)) u_wr_dec (
        .allwr_n  (allwr_n),
        .lanewr_n (lanewr_n),
        .lane_n   (lane_n),
        .lane_req (lane_req)
    );

    bsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_ok    (sel_ok),
        .sleep     (sleep),
        .pstrb_n   (pstrb_n),
        .cstrb_n   (cstrb_n),
        .step_n    (step_n),
        .ilv_order (ilv_order),
        .lane_req  (lane_req),
        .addr      (addr),
        .acc_go    (acc_go),
        .acc_addr  (acc_addr),
        .lane_we   (lane_we),
        .rd_pend   (rd_pend),
        .rd_addr   (rd_addr)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we),
        .wr_addr (acc_addr),
        .wdata   (wdata),
        .rd_pend (rd_pend),
        .rd_addr (rd_addr),
        .rdata   (rdata),
        .vld     (arr_vld)
    );

    assign rvalid = arr_vld && !out_en_n && !sleep;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep,
    input logic             pstrb_n,
    input logic             cstrb_n,
    input logic             allwr_n,
    input logic             sel_ok,
    input logic             acc_go,
    input logic             rd_pend,
    input logic             vld,
    input logic [LANES-1:0] lane_we
);

    assert_pread_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pstrb_n |-> (lane_we == '0));

    assert_allwr_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && pstrb_n && !allwr_n) |-> (lane_we == '1));

    assert_sleep_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!acc_go && lane_we == '0));

    assert_pipe_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |=> vld);

    assert_pipe_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(rd_pend));

    assert_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok && (!pstrb_n || !cstrb_n)) |-> !acc_go);

endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep   (sleep),
    .pstrb_n (pstrb_n),
    .cstrb_n (cstrb_n),
    .allwr_n (allwr_n),
    .sel_ok  (sel_ok),
    .acc_go  (acc_go),
    .rd_pend (rd_pend),
    .vld     (arr_vld),
    .lane_we (lane_we)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel0_n, sel_hi, sel1_n;
    logic        pstrb_n, cstrb_n, step_n, allwr_n, lanewr_n;
    logic [3:0]  lane_n;
    logic [5:0]  addr;
    logic [35:0] wdata;
    logic        ilv_order, sleep, out_en_n;
    logic [35:0] rdata;
    logic        rvalid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_sram u_burst_sram (
        .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel_hi(sel_hi), .sel1_n(sel1_n),
        .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .step_n(step_n), .allwr_n(allwr_n),
        .lanewr_n(lanewr_n), .lane_n(lane_n), .addr(addr), .wdata(wdata),
        .ilv_order(ilv_order), .sleep(sleep), .out_en_n(out_en_n),
        .rdata(rdata), .rvalid(rvalid)
    );

    // Lane words written as {lane3, lane2, lane1, lane0}
    localparam logic [35:0] W40 = {9'h043, 9'h042, 9'h041, 9'h040};
    localparam logic [35:0] W4  = {9'h0E3, 9'h0E2, 9'h0E1, 9'h0E0};
    localparam logic [35:0] W5  = {9'h053, 9'h052, 9'h051, 9'h050};
    localparam logic [35:0] W6  = {9'h063, 9'h062, 9'h061, 9'h060};
    localparam logic [35:0] W7  = {9'h073, 9'h072, 9'h071, 9'h070};
    localparam logic [35:0] WPART = {9'h1AA, 9'h1BB, 9'h1CC, 9'h1DD};
    localparam logic [35:0] W6P = {9'h063, 9'h1BB, 9'h061, 9'h1DD};
    localparam logic [35:0] W7F = {9'h0A3, 9'h0A2, 9'h0A1, 9'h0A0};

    typedef struct packed {
        logic        ps_n, cs_n, st_n, aw_n, lw_n;
        logic [3:0]  ln;
        logic [5:0]  a;
        logic [35:0] wd;
        logic        ev;
        logic [35:0] ed;
        logic [3:0]  rq;
    } vec_t;

    function automatic vec_t V(input logic ps, input logic cs, input logic st,
                               input logic aw, input logic lw, input logic [3:0] ln,
                               input logic [5:0] a, input logic [35:0] wd,
                               input logic ev, input logic [35:0] ed, input logic [3:0] rq);
        vec_t v;
        v.ps_n = ps; v.cs_n = cs; v.st_n = st; v.aw_n = aw; v.lw_n = lw;
        v.ln = ln; v.a = a; v.wd = wd; v.ev = ev; v.ed = ed; v.rq = rq;
        return v;
    endfunction

    // Expected fields: outputs seen just before this vector is driven,
    // i.e. the result of the vector two rows earlier (R7 latency).
    localparam int NVEC = 19;
    localparam vec_t VEC [NVEC] = '{
        V(1,0,1,0,1,4'hF,6'd4,W40,  0,36'h0,11), // R11 reset state; write 4
        V(1,1,0,0,1,4'hF,6'd0,W5,   0,36'h0,4),  // R4 step write 5
        V(1,1,0,0,1,4'hF,6'd0,W6,   0,36'h0,4),  // step write 6
        V(1,1,0,0,1,4'hF,6'd0,W7,   0,36'h0,4),  // step write 7
        V(1,1,0,0,1,4'hF,6'd0,W4,   0,36'h0,4),  // R4 wrap: writes 4 again
        V(0,1,1,0,1,4'hF,6'd5,36'h0,0,36'h0,3),  // R3 processor strobe reads despite write
        V(1,1,0,1,1,4'hF,6'd0,36'h0,0,36'h0,4),  // step read 6
        V(1,1,0,1,1,4'hF,6'd0,36'h0,1,W5,   3),  // step read 7
        V(1,1,0,1,1,4'hF,6'd0,36'h0,1,W6,   5),  // step read wraps to 4
        V(1,1,1,1,1,4'hF,6'd0,36'h0,1,W7,   5),
        V(1,1,1,1,1,4'hF,6'd0,36'h0,1,W4,   5),  // R5 wrap to base word
        V(1,0,1,1,0,4'b1010,6'd6,WPART,0,36'h0,4), // R4 idle made no access; R1 lanes 0,2
        V(1,0,1,1,1,4'h0,6'd6,36'h0,0,36'h0,7),  // R1 gate off: read
        V(1,1,1,1,1,4'hF,6'd0,36'h0,0,36'h0,7),
        V(1,1,1,1,1,4'hF,6'd0,36'h0,1,W6P,  1),  // R1 merged lanes, no zero write
        V(1,0,1,0,0,4'hF,6'd7,W7F,  0,36'h0,2),  // R2 global write over lanes off
        V(0,1,1,1,1,4'hF,6'd7,36'h0,0,36'h0,7),
        V(1,1,1,1,1,4'hF,6'd0,36'h0,0,36'h0,7),
        V(1,1,1,1,1,4'hF,6'd0,36'h0,1,W7F,  2)   // R2 all lanes stored
    };

    task automatic drive(input logic ps, input logic cs, input logic st, input logic aw,
                         input logic lw, input logic [3:0] ln, input logic [5:0] a,
                         input logic [35:0] wd);
        pstrb_n = ps; cstrb_n = cs; step_n = st; allwr_n = aw; lanewr_n = lw;
        lane_n = ln; addr = a; wdata = wd;
    endtask

    task automatic idle();
        drive(1,1,1,1,1,4'hF,6'd0,36'h0);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string rq, input logic ev, input logic [35:0] ed);
        n_chk++;
        if (rvalid !== ev || (ev && rdata !== ed)) begin
            n_fail++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     rq, rvalid, rdata, ev, ed);
        end
    endtask

    // Four-beat read burst, results checked two edges after each issue
    task automatic burst4(input logic [5:0] base, input logic ilv, input string rq,
                          input logic [35:0] e0, input logic [35:0] e1,
                          input logic [35:0] e2, input logic [35:0] e3);
        logic [35:0] exp_w [4];
        exp_w[0] = e0; exp_w[1] = e1; exp_w[2] = e2; exp_w[3] = e3;
        ilv_order = ilv;
        for (int k = 0; k < 6; k++) begin
            if (k >= 2) check(rq, 1'b1, exp_w[k-2]);
            if (k == 0)     drive(0,1,1,1,1,4'hF,base,36'h0);
            else if (k < 4) drive(1,1,0,1,1,4'hF,6'd0,36'h0);
            else            idle();
            tick();
        end
        ilv_order = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        sel0_n = 1'b0; sel_hi = 1'b1; sel1_n = 1'b0;
        ilv_order = 1'b0; sleep = 1'b0; out_en_n = 1'b0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        n_chk++;
        if (rvalid !== 1'b0 || rdata !== 36'h0) begin
            n_fail++;
            $display("FAIL R11: rvalid=%0b rdata=%h expected rvalid=0 rdata=0", rvalid, rdata);
        end

        for (int i = 0; i < NVEC; i++) begin
            check($sformatf("R%0d", VEC[i].rq), VEC[i].ev, VEC[i].ed);
            drive(VEC[i].ps_n, VEC[i].cs_n, VEC[i].st_n, VEC[i].aw_n, VEC[i].lw_n,
                  VEC[i].ln, VEC[i].a, VEC[i].wd);
            tick();
        end
        idle();
        tick();
        tick();

        // R5 linear from an unaligned base: 6,7,4,5
        burst4(6'd6, 1'b0, "R5", W6P, W7F, W4, W5);
        // R6 interleaved: base 5 -> 5,4,7,6 ; base 7 -> 7,6,5,4
        burst4(6'd5, 1'b1, "R6", W5, W4, W7F, W6P);
        burst4(6'd7, 1'b1, "R6", W7F, W6P, W5, W4);

        // R8: deselected start ends the burst
        drive(0,1,1,1,1,4'hF,6'd5,36'h0);
        tick();
        sel_hi = 1'b0;
        drive(1,0,1,1,1,4'hF,6'd4,36'h0);
        tick();
        sel_hi = 1'b1;
        check("R8", 1'b1, W5);
        drive(1,1,0,1,1,4'hF,6'd0,36'h0);
        tick();
        check("R8", 1'b0, 36'h0);
        idle();
        tick();
        check("R8", 1'b0, 36'h0);

        // R9: output enable masks valid
        drive(0,1,1,1,1,4'hF,6'd4,36'h0);
        tick();
        idle();
        tick();
        out_en_n = 1'b1;
        #1 check("R9", 1'b0, 36'h0);
        out_en_n = 1'b0;
        #1 check("R9", 1'b1, W4);
        tick();
        check("R7", 1'b0, 36'h0); // single-cycle valid pulse

        // R10: sleep blocks strobes and keeps array
        sleep = 1'b1;
        drive(1,0,1,0,1,4'hF,6'd5,36'h0);
        tick();
        drive(0,1,1,1,1,4'hF,6'd4,36'h0);
        tick();
        sleep = 1'b0;
        idle();
        tick();
        check("R10", 1'b0, 36'h0);
        drive(0,1,1,1,1,4'hF,6'd5,36'h0);
        tick();
        idle();
        tick();
        check("R10", 1'b1, W5);
        sleep = 1'b1;
        #1 check("R9", 1'b0, 36'h0);
        sleep = 1'b0;
        tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R7: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule